// File: doc/BRIEF.md
# Two-Wire DAC Writer Over a Register Port

This block drives a write-only two-wire serial bus without owning any pins. The two bus lines are two bits of a power-control register, and every change of line level goes out as one complete write of that register. The write goes through a command port that carries an address and an 8-bit value, with a valid/ready handshake. The register's other bits control supplies and must not move while the bus is toggled, so each request carries a base value for them.

A request carries a base value and a data byte. The block then plays a fixed transaction to a voltage DAC. The transaction is a start condition, the device byte 0x9C, a dummy acknowledge, the sub-address byte 0x00, a dummy acknowledge, the request's data byte, a dummy acknowledge, and a stop condition. The acknowledge slots are blind: the clock pulses with data low and nothing is read back. From the accepted request until the last stop write is taken, the block reports busy and ignores further requests.

Top module: `dac_wire_writer`

## Requirements
- R1: Every write on the command port targets register address 0x03 (parameter `REG_ADDR`).
- R2: Every written value equals the request base with bits 1:0 cleared, ORed with the clock level in bit 0 and the data level in bit 1.
- R3: A transaction opens with three writes in this order: line bits {data,clock} = 11, then 01, then 00.
- R4: Each payload bit takes three writes: data at the bit's level with clock 0, the same data with clock 1, then the same data with clock 0. Bits go most-significant first.
- R5: The payload is byte 0x9C, then byte 0x00, then the request data byte. Each byte is followed by an acknowledge slot of three writes with data 0 and the clock pattern 0,1,0. A transaction has exactly 87 writes.
- R6: A transaction closes with three writes in this order: {data,clock} = 00, then 01, then 11, so both lines are left high.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_value` does not change. The next write appears only after the current one is accepted.
- R8: After reset `busy` and `cmd_valid` are low. `busy` rises in the cycle after a request is accepted and falls in the cycle after the last stop write is accepted. `cmd_valid` is high only while busy.
- R9: A request presented while busy is ignored. The transaction in progress keeps its base and data.
- R10: Two consecutive accepted writes never differ in both line bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_base | input | 8 | Value for the non-bus bits of the register |
| req_data | input | 8 | Byte to send to the DAC |
| busy | output | 1 | Transaction in progress |
| cmd_valid | output | 1 | Register write offered |
| cmd_ready | input | 1 | Downstream accepts the offered write |
| cmd_addr | output | 8 | Register address of the write |
| cmd_value | output | 8 | Register value of the write |

## Verification
The bench targets the bit ordering within each byte: a design that sent bits least-significant first would corrupt 0x9C and any asymmetric data byte, while 0x00 and 0xFF would not reveal it. It stalls the handshake for many cycles, so a design that advanced without ready would skip writes and run short of 87. It sets the low base bits to show that they never leak onto the lines. It also raises a competing request in the middle of a transaction, which a design that failed to block requests would pick up as a corrupted base or data byte.

// File: rtl/dww_pkg.sv
package dww_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_BIT   = 2'd1,
    PH_STOP  = 2'd2
  } dww_phase_e;

  localparam int SUB_STEPS = 3;
endpackage

// File: rtl/dww_seq.sv
module dww_seq
  import dww_pkg::*;
#(
  parameter int BITS   = 8,
  parameter int NBYTES = 3,
  localparam int BYTE_W = $clog2(NBYTES),
  localparam int BIT_W  = $clog2(BITS + 1),
  localparam int SUB_W  = $clog2(SUB_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output dww_phase_e        phase,
  output logic [BYTE_W-1:0] byte_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [SUB_W-1:0]  sub,
  output logic              last
);
  localparam logic [SUB_W-1:0]  SUB_END  = SUB_W'(SUB_STEPS - 1);
  localparam logic [BIT_W-1:0]  BIT_ACK  = BIT_W'(BITS);
  localparam logic [BYTE_W-1:0] BYTE_END = BYTE_W'(NBYTES - 1);

  dww_phase_e        ph_q, ph_d;
  logic [BYTE_W-1:0] by_q, by_d;
  logic [BIT_W-1:0]  bi_q, bi_d;
  logic [SUB_W-1:0]  sb_q, sb_d;
  logic              step_en;

  assign step_en = clear | advance;

  always_comb begin
    ph_d = ph_q;
    by_d = by_q;
    bi_d = bi_q;
    sb_d = sb_q;
    if (clear) begin
      ph_d = PH_START;
      by_d = '0;
      bi_d = '0;
      sb_d = '0;
    end else if (advance) begin
      if (sb_q != SUB_END) begin
        sb_d = sb_q + 1'b1;
      end else begin
        sb_d = '0;
        case (ph_q)
          PH_START: begin
            ph_d = PH_BIT;
            by_d = '0;
            bi_d = '0;
          end
          PH_BIT: begin
            if (bi_q != BIT_ACK) begin
              bi_d = bi_q + 1'b1;
            end else begin
              bi_d = '0;
              if (by_q != BYTE_END) by_d = by_q + 1'b1;
              else                  ph_d = PH_STOP;
            end
          end
          default: ph_d = PH_START;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_START;
      by_q <= '0;
      bi_q <= '0;
      sb_q <= '0;
    end else if (step_en) begin
      ph_q <= ph_d;
      by_q <= by_d;
      bi_q <= bi_d;
      sb_q <= sb_d;
    end
  end

  assign phase    = ph_q;
  assign byte_idx = by_q;
  assign bit_idx  = bi_q;
  assign sub      = sb_q;
  assign last     = (ph_q == PH_STOP) && (sb_q == SUB_END);
endmodule

// File: rtl/dww_line.sv
module dww_line
  import dww_pkg::*;
#(
  parameter int BITS = 8,
  localparam int BIT_W = $clog2(BITS + 1),
  localparam int SUB_W = $clog2(SUB_STEPS)
) (
  input  dww_phase_e       phase,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [SUB_W-1:0] sub,
  input  logic [BITS-1:0]  cur_byte,
  output logic             scl,
  output logic             sda
);
  logic [BITS-1:0] shifted;

  // Shifting by the ack index (BITS) empties the byte, so the ack slot sends 0.
  assign shifted = cur_byte << bit_idx;

  always_comb begin
    case (phase)
      PH_START: begin
        scl = (sub != SUB_W'(2));
        sda = (sub == SUB_W'(0));
      end
      PH_BIT: begin
        scl = (sub == SUB_W'(1));
        sda = shifted[BITS-1];
      end
      default: begin
        scl = (sub != SUB_W'(0));
        sda = (sub == SUB_W'(2));
      end
    endcase
  end
endmodule

// File: rtl/dac_wire_writer.sv
module dac_wire_writer
  import dww_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter int              BITS     = 8,
  parameter logic [7:0]      REG_ADDR = 8'h03,
  parameter int              CLK_BIT  = 0,
  parameter int              DAT_BIT  = 1,
  parameter logic [BITS-1:0] DEV_BYTE = 8'h9C,
  parameter logic [BITS-1:0] SUB_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_base,
  input  logic [BITS-1:0]   req_data,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_value
);
  localparam int NBYTES = 3;
  localparam int BYTE_W = $clog2(NBYTES);
  localparam int BIT_W  = $clog2(BITS + 1);
  localparam int SUB_W  = $clog2(SUB_STEPS);
  localparam logic [DATA_W-1:0] LINE_MASK =
    (DATA_W'(1) << CLK_BIT) | (DATA_W'(1) << DAT_BIT);

  logic              busy_q, busy_d;
  logic [DATA_W-1:0] base_q;
  logic [BITS-1:0]   data_q;
  logic              accept, fire, last;
  dww_phase_e        phase;
  logic [BYTE_W-1:0] byte_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [SUB_W-1:0]  sub;
  logic [BITS-1:0]   cur_byte;
  logic              scl, sda;

  assign accept = req_valid & ~busy_q;
  assign fire   = busy_q & cmd_ready;

  always_comb begin
    busy_d = busy_q;
    if (accept)           busy_d = 1'b1;
    else if (fire & last) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      base_q <= req_base & ~LINE_MASK;
      data_q <= req_data;
    end
  end

  dww_seq #(.BITS(BITS), .NBYTES(NBYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .advance  (fire),
    .phase    (phase),
    .byte_idx (byte_idx),
    .bit_idx  (bit_idx),
    .sub      (sub),
    .last     (last)
  );

  always_comb begin
    case (byte_idx)
      BYTE_W'(0): cur_byte = DEV_BYTE;
      BYTE_W'(1): cur_byte = SUB_BYTE;
      default:    cur_byte = data_q;
    endcase
  end

  dww_line #(.BITS(BITS)) u_line (
    .phase    (phase),
    .bit_idx  (bit_idx),
    .sub      (sub),
    .cur_byte (cur_byte),
    .scl      (scl),
    .sda      (sda)
  );

  assign busy      = busy_q;
  assign cmd_valid = busy_q;
  assign cmd_addr  = ADDR_W'(REG_ADDR);
  assign cmd_value = base_q | (DATA_W'(scl) << CLK_BIT) | (DATA_W'(sda) << DAT_BIT);
endmodule

// File: rtl/dww_checker.sv
module dww_checker #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h03,
  parameter int         CLK_BIT  = 0,
  parameter int         DAT_BIT  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_value
);
  localparam logic [DATA_W-1:0] LMASK =
    (DATA_W'(1) << CLK_BIT) | (DATA_W'(1) << DAT_BIT);

  logic [DATA_W-1:0] prev_q;
  logic              have_prev_q;
  logic              fire;

  assign fire = cmd_valid & cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (fire) begin
      prev_q      <= cmd_value;
      have_prev_q <= 1'b1;
    end
  end

  assert_addr_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr == ADDR_W'(REG_ADDR));

  assert_lines_high_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (prev_q & LMASK) == LMASK);

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_value)));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cmd_valid && cmd_ready));

  assert_base_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(cmd_value & ~LMASK)));

  assert_one_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev_q) |-> $countones((cmd_value ^ prev_q) & LMASK) <= 1);
endmodule

bind dac_wire_writer dww_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
  .CLK_BIT(CLK_BIT), .DAT_BIT(DAT_BIT)
) u_dww_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_value (cmd_value)
);

// File: tb/tb_dac_wire_writer.sv
module tb_dac_wire_writer;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_base;
  logic [7:0] req_data;
  logic       busy;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [7:0] cmd_addr;
  logic [7:0] cmd_value;

  int checks;
  int fails;
  int cycles;
  bit done;

  dac_wire_writer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_data(req_data), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_value(cmd_value)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected value of write number k (0..86) of a transaction.
  function automatic logic [7:0] exp_val(input logic [7:0] base, input logic [7:0] data,
                                         input int k);
    logic clkv, datv;
    logic [7:0] by;
    int j, r, bi, sb;
    if (k < 3) begin
      clkv = (k != 2);
      datv = (k == 0);
    end else if (k >= 84) begin
      sb = k - 84;
      clkv = (sb != 0);
      datv = (sb == 2);
    end else begin
      j  = k - 3;
      r  = j % 27;
      bi = r / 3;
      sb = r % 3;
      case (j / 27)
        0: by = 8'h9C;
        1: by = 8'h00;
        default: by = data;
      endcase
      clkv = (sb == 1);
      datv = (bi < 8) ? by[7 - bi] : 1'b0;
    end
    return (base & 8'hFC) | {6'b0, datv, clkv};
  endfunction

  function automatic string tag_of(input int k);
    if (k < 3) return "R3";
    if (k >= 84) return "R6";
    if (((k - 3) % 27) >= 24) return "R5";
    return "R4";
  endfunction

  function automatic bit pick_ready(input int mode);
    case (mode)
      0: return 1'b1;
      1: return ($urandom % 8) == 0;
      default: return ($urandom % 4) != 0;
    endcase
  endfunction

  task automatic run_txn(input logic [7:0] base, input logic [7:0] data,
                         input int mode, input bit inject);
    int n;
    int wait_c;
    bit stalled;
    bit r;
    bit have_prev;
    int bad;
    logic [7:0] hold;
    logic [7:0] prev;
    @(negedge clk);
    req_valid = 1'b1;
    req_base  = base;
    req_data  = data;
    cmd_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && cmd_valid, "R8 busy after accept", {busy, cmd_valid}, 2'b11);
    n = 0; wait_c = 0; stalled = 0; have_prev = 0; bad = 0;
    while (n < 87 && wait_c < 20000) begin
      if (stalled) chk(cmd_valid && cmd_value == hold, "R7 stalled write held", cmd_value, hold);
      if (inject && n == 20) begin
        req_valid = 1'b1;
        req_base  = ~base;
        req_data  = ~data;
      end
      if (inject && n == 60) req_valid = 1'b0;
      r = pick_ready(mode);
      cmd_ready = r;
      if (cmd_valid && r) begin
        if (cmd_value != exp_val(base, data, n)) bad++;
        chk(cmd_value == exp_val(base, data, n), tag_of(n), cmd_value, exp_val(base, data, n));
        chk((cmd_value & 8'hFC) == (base & 8'hFC), "R2 base bits", cmd_value, base & 8'hFC);
        chk(cmd_addr == 8'h03, "R1 address", cmd_addr, 8'h03);
        if (have_prev)
          chk($countones((cmd_value ^ prev) & 8'h03) <= 1, "R10 one line per write",
              cmd_value, prev);
        prev = cmd_value;
        have_prev = 1'b1;
        n++;
      end
      stalled = cmd_valid && !r;
      hold = cmd_value;
      @(negedge clk);
      wait_c++;
    end
    cmd_ready = 1'b1;
    req_valid = 1'b0;
    if (inject) chk(bad == 0, "R9 request while busy ignored", bad, 0);
    chk(n == 87, "R5 write count", n, 87);
    chk(!busy && !cmd_valid, "R8 idle after stop", {busy, cmd_valid}, 2'b00);
    repeat (3) begin
      @(negedge clk);
      chk(!cmd_valid, "R5 no extra write", cmd_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    checks = 0; fails = 0; cycles = 0; done = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_data = '0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid, "R8 reset state", {busy, cmd_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R8 idle after reset", {busy, cmd_valid}, 2'b00);

    run_txn(8'h00, 8'h7D, 0, 1'b0);   // asymmetric byte, no stalls
    run_txn(8'h1F, 8'h00, 1, 1'b0);   // low base bits set (R2), long stalls
    run_txn(8'hE0, 8'hFF, 2, 1'b1);   // competing request mid-transaction (R9)
    run_txn(8'h14, 8'h01, 2, 1'b0);   // only LSB set, MSB-first order (R4)
    for (int i = 0; i < 6; i++) begin
      run_txn(8'($urandom), 8'($urandom), i % 3, (i % 2) == 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule